// File: doc/BRIEF.md
# Page-Class Bank Selector for a Tiled Last-Level Cache

This block steers each core request into a last-level cache that is built from one bank per core. The banks form a square grid. Every page carries a class in its translation entry, and that class changes how the address picks a bank. Private data always goes to the requester's own bank. Instruction pages shared between cores spread over a 2x2 cluster anchored at the requester. Shared data pages spread over the whole grid, so each block has exactly one home bank.

The same request also passes an access-kind check. When the kind of access does not fit the page's class, or a core touches another core's private page, the request is refused. The response then carries a fault flag and no bank. Both the bank number and the fault flag are registered, so the response arrives one clock after the request.

Top module: `page_bank_selector`

## Requirements
- R1: During and after a synchronous active-high reset, and until the first request, `rsp_valid`, `rsp_fault` and `rsp_bank` are all 0.
- R2: Each request accepted on a rising edge gives `rsp_valid`=1 on the next edge. A cycle with no request gives `rsp_valid`=0 on the next edge.
- R3: The page class encoding is: 0 = private data, 1 = shared instruction, 2 = shared data, 3 = reserved. Any access to a class-3 page is faulted.
- R4: A data access (`req_ifetch`=0) to a private page whose `pte_owner` equals `req_core` is sent to bank `req_core` with no fault.
- R5: Banks are numbered row*4 + column on the default 4x4 grid, and a core's number is its local bank. An instruction fetch to a shared-instruction page goes to column (c + a0) mod 4 and row (r + a1) mod 4. Here (r, c) is the requester's position, a0 is address bit 6 and a1 is address bit 7, the two bits just above the 6-bit block offset.
- R6: A data access to a shared-data page goes to the bank given by address bits [9:6].
- R7: An instruction fetch to any page that is not shared-instruction is faulted.
- R8: A data access to a shared-instruction page is faulted.
- R9: A data access to a private page whose `pte_owner` differs from `req_core` is faulted.
- R10: A faulted response has `rsp_valid`=1, `rsp_fault`=1 and `rsp_bank`=0.
- R11: For shared-instruction and shared-data pages, `pte_owner` has no effect on the bank or on the fault flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | ADDR_W (32) | Physical address |
| req_core | input | BANK_W (4) | Requesting core id |
| req_ifetch | input | 1 | 1 = instruction fetch, 0 = data access |
| pte_class | input | 2 | Page class from the translation entry |
| pte_owner | input | BANK_W (4) | Owning core recorded for the page |
| rsp_valid | output | 1 | Response present |
| rsp_bank | output | BANK_W (4) | Target bank |
| rsp_fault | output | 1 | Request refused for a class or owner violation |

## Verification
The bench builds the block with its default parameters: a 4x4 grid, a 6-bit block offset and 32-bit addresses. With that size the full cross product fits in one sweep: every requester, every class code, both access kinds, every recorded owner and every value of the four bank-select address bits. This covers every cluster wrap at the grid edges and every owner mismatch. The upper address bits take varied values, and idle cycles are mixed in to check the response-valid timing.

// File: rtl/pbs_pkg.sv
package pbs_pkg;

    typedef enum logic [1:0] {
        PC_PRIV    = 2'd0,
        PC_SHINSTR = 2'd1,
        PC_SHDATA  = 2'd2,
        PC_RSVD    = 2'd3
    } page_class_e;

    typedef enum logic [1:0] {
        FLT_NONE  = 2'd0,
        FLT_KIND  = 2'd1,
        FLT_OWNER = 2'd2,
        FLT_RSVD  = 2'd3
    } fault_e;

    localparam int CLUSTER_SIDE = 2;
    localparam int CLUSTER_SIZE = CLUSTER_SIDE * CLUSTER_SIDE;
    localparam int CLUSTER_SEL_W = $clog2(CLUSTER_SIZE);

    function automatic int wrap_step(input int pos, input int step, input int dim);
        return (pos + step) % dim;
    endfunction

endpackage

// File: rtl/pbs_class_check.sv
module pbs_class_check
    import pbs_pkg::*;
#(
    parameter int BANK_W = 4
) (
    input  page_class_e         cls,
    input  logic                ifetch,
    input  logic [BANK_W-1:0]   core,
    input  logic [BANK_W-1:0]   owner,
    output fault_e              reason
);
    always_comb begin
        reason = FLT_NONE;
        unique case (cls)
            PC_RSVD:    reason = FLT_RSVD;
            PC_SHINSTR: if (!ifetch) reason = FLT_KIND;
            PC_SHDATA:  if (ifetch)  reason = FLT_KIND;
            PC_PRIV: begin
                if (ifetch)              reason = FLT_KIND;
                else if (owner != core)  reason = FLT_OWNER;
            end
            default:    reason = FLT_RSVD;
        endcase
    end

    always_comb begin
        a_rsvd_always_faults_r3: assert (cls != PC_RSVD || reason == FLT_RSVD);
    end
endmodule

// File: rtl/pbs_index_calc.sv
module pbs_index_calc
    import pbs_pkg::*;
#(
    parameter int GRID_DIM = 4,
    parameter int BANK_W   = 4
) (
    input  page_class_e                cls,
    input  logic [BANK_W-1:0]          core,
    input  logic [BANK_W-1:0]          sel_bits,
    output logic [BANK_W-1:0]          bank
);
    logic [BANK_W-1:0] member [CLUSTER_SIZE];
    logic [CLUSTER_SEL_W-1:0] member_sel;

    assign member_sel = sel_bits[CLUSTER_SEL_W-1:0];

    for (genvar m = 0; m < CLUSTER_SIZE; m++) begin : g_member
        localparam int DX = m % CLUSTER_SIDE;
        localparam int DY = m / CLUSTER_SIDE;
        always_comb begin
            int col;
            int row;
            col = wrap_step(int'(core) % GRID_DIM, DX, GRID_DIM);
            row = wrap_step(int'(core) / GRID_DIM, DY, GRID_DIM);
            member[m] = BANK_W'(row * GRID_DIM + col);
        end
    end

    always_comb begin
        unique case (cls)
            PC_PRIV:    bank = core;
            PC_SHINSTR: bank = member[member_sel];
            PC_SHDATA:  bank = sel_bits;
            default:    bank = '0;
        endcase
    end
endmodule

// File: rtl/page_bank_selector.sv
module page_bank_selector
    import pbs_pkg::*;
#(
    parameter int GRID_DIM  = 4,
    parameter int ADDR_W    = 32,
    parameter int BLK_OFF_W = 6,
    localparam int NUM_BANKS = GRID_DIM * GRID_DIM,
    localparam int BANK_W    = $clog2(NUM_BANKS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [BANK_W-1:0]    req_core,
    input  logic                 req_ifetch,
    input  logic [1:0]           pte_class,
    input  logic [BANK_W-1:0]    pte_owner,
    output logic                 rsp_valid,
    output logic [BANK_W-1:0]    rsp_bank,
    output logic                 rsp_fault
);
    localparam int SEL_LO = BLK_OFF_W;
    localparam int SEL_HI = BLK_OFF_W + BANK_W - 1;

    page_class_e       cls;
    fault_e            reason;
    logic [BANK_W-1:0] sel_bits;
    logic [BANK_W-1:0] next_bank;
    logic              unused_addr_bits;

    assign cls      = page_class_e'(pte_class);
    assign sel_bits = req_addr[SEL_HI:SEL_LO];
    assign unused_addr_bits = ^{req_addr[ADDR_W-1:SEL_HI+1], req_addr[SEL_LO-1:0]};

    pbs_class_check #(.BANK_W(BANK_W)) u_check (
        .cls    (cls),
        .ifetch (req_ifetch),
        .core   (req_core),
        .owner  (pte_owner),
        .reason (reason)
    );

    pbs_index_calc #(.GRID_DIM(GRID_DIM), .BANK_W(BANK_W)) u_index (
        .cls      (cls),
        .core     (req_core),
        .sel_bits (sel_bits),
        .bank     (next_bank)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_bank  <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid && reason == FLT_NONE) begin
                rsp_fault <= 1'b0;
                rsp_bank  <= next_bank;
            end else begin
                rsp_fault <= req_valid;
                rsp_bank  <= '0;
            end
        end
    end

    p_resp_follows_req_r2: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    p_idle_follows_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);
    p_private_local_r4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && cls == PC_PRIV && !req_ifetch && pte_owner == req_core)
        |=> (!rsp_fault && rsp_bank == $past(req_core)));
    p_shdata_home_r6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && cls == PC_SHDATA && !req_ifetch)
        |=> (!rsp_fault && rsp_bank == $past(req_addr[SEL_HI:SEL_LO])));
    p_fetch_misclass_r7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ifetch && cls != PC_SHINSTR) |=> rsp_fault);
    p_data_on_instr_r8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ifetch && cls == PC_SHINSTR) |=> rsp_fault);
    p_foreign_private_r9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ifetch && cls == PC_PRIV && pte_owner != req_core)
        |=> rsp_fault);
    p_fault_shape_r10: assert property (@(posedge clk) disable iff (rst)
        rsp_fault |-> (rsp_valid && rsp_bank == '0));
endmodule

// File: tb/page_bank_selector_test.sv
`timescale 1ns/1ps
module page_bank_selector_test;
    localparam int G = 4;
    localparam int BW = 4;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [31:0] req_addr;
    logic [3:0]  req_core;
    logic        req_ifetch;
    logic [1:0]  pte_class;
    logic [3:0]  pte_owner;
    logic        rsp_valid;
    logic [3:0]  rsp_bank;
    logic        rsp_fault;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    page_bank_selector uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_core(req_core), .req_ifetch(req_ifetch), .pte_class(pte_class),
        .pte_owner(pte_owner), .rsp_valid(rsp_valid), .rsp_bank(rsp_bank),
        .rsp_fault(rsp_fault)
    );

    task automatic check(input string tag, input int act, input int expv);
        n_checks++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #1000000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            summary();
        end
    end

    initial begin
        rst = 1'b1; req_valid = 0; req_addr = 0; req_core = 0;
        req_ifetch = 0; pte_class = 0; pte_owner = 0;
        repeat (3) @(negedge clk);
        check("R1 rsp_valid in reset", int'(rsp_valid), 0);
        check("R1 rsp_fault in reset", int'(rsp_fault), 0);
        check("R1 rsp_bank in reset", int'(rsp_bank), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 rsp_valid after reset", int'(rsp_valid), 0);

        for (int core = 0; core < 16; core++) begin
            for (int cls = 0; cls < 4; cls++) begin
                for (int kf = 0; kf < 2; kf++) begin
                    for (int own = 0; own < 16; own++) begin
                        for (int idx = 0; idx < 16; idx++) begin
                            bit ef;
                            int eb;
                            string tag;
                            req_valid  = 1'b1;
                            req_core   = 4'(core);
                            pte_class  = 2'(cls);
                            req_ifetch = 1'(kf);
                            pte_owner  = 4'(own);
                            req_addr   = {22'($urandom), 4'(idx), 6'($urandom)};
                            ef = (cls == 3) || (kf == 1 && cls != 1) ||
                                 (kf == 0 && cls == 1) ||
                                 (kf == 0 && cls == 0 && own != core);
                            if (cls == 3)                   tag = "R3";
                            else if (kf == 1 && cls != 1)   tag = "R7";
                            else if (kf == 0 && cls == 1)   tag = "R8";
                            else if (cls == 0 && own != core) tag = "R9";
                            else if (cls == 0)              tag = "R4";
                            else if (cls == 1)              tag = "R5/R11";
                            else                            tag = "R6/R11";
                            if (ef) eb = 0;
                            else if (cls == 0) eb = core;
                            else if (cls == 1)
                                eb = (((core / G) + (idx / 2) % 2) % G) * G
                                     + ((core % G) + idx % 2) % G;
                            else eb = idx;
                            @(posedge clk);
                            @(negedge clk);
                            check({tag, " R2 valid"}, int'(rsp_valid), 1);
                            check({tag, " fault"}, int'(rsp_fault), int'(ef));
                            check({tag, ef ? " R10 bank" : " bank"}, int'(rsp_bank), eb);
                        end
                    end
                end
                req_valid = 1'b0;
                @(posedge clk);
                @(negedge clk);
                check("R2 idle valid", int'(rsp_valid), 0);
                check("R2 idle fault", int'(rsp_fault), 0);
            end
        end

        finished = 1;
        summary();
    end
endmodule